// File: doc/BRIEF.md
# Iterative IDEA Block Encryption Core

This block encrypts one 64-bit data block under a 128-bit key with the IDEA cipher. It works on the block as four 16-bit words. Each of eight rounds mixes the words using only three operations: XOR, addition modulo 2^16, and multiplication modulo 2^16+1. No lookup tables are used. A final output step then applies four more subkeys. One round is computed per clock cycle, so a single datapath is reused nine times.

The core expands the 52 encryption subkeys from the key it holds. The first eight subkeys are the key cut into 16-bit pieces, most significant piece first. The next eight come from the key rotated left by 25 bits, and so on. A caller raises `start` for one cycle with the plaintext and key on their buses. Nine clocks later `done` pulses for one cycle and the ciphertext appears on `ct_o`. The ciphertext stays there until the next result replaces it.

Top module: `idea_enc_core`

## Requirements
- R1: After a synchronous reset, `done_o` is 0 and `ct_o` is all zeros.
- R2: A start that is accepted at clock edge E makes `done_o` high for exactly one cycle, just after edge E+9, and low at every other time.
- R3: On `done_o`, `ct_o` equals the IDEA encryption of the captured plaintext under the captured key. Word 1 is bits 63:48 of the block and word 4 is bits 15:0. For example, key 0001 0002 0003 0004 0005 0006 0007 0008 with plaintext 0000 0001 0002 0003 gives 11FB ED2B 0198 6DE5.
- R4: Multiplication is modulo 65537, and a 16-bit operand of 0 stands for 65536. All-zero and all-ones operands give correct ciphertext.
- R5: Subkey j (0 to 51) is the 16-bit field at bit 127−16·(j mod 8) downward of the key rotated left by 25·floor(j/8). Each round uses six consecutive subkeys and the output step uses the last four.
- R6: A `start` that arrives while an encryption is in progress is ignored. It does not change that result and does not cause an extra `done_o` pulse.
- R7: `ct_o` changes only at the edge that raises `done_o`. It holds its value between results.
- R8: The plaintext and key are captured at the accepted start edge. Changing the buses afterwards has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to encrypt the block and key on the buses |
| pt_i | input | 64 | Plaintext block, word 1 in bits 63:48 |
| key_i | input | 128 | Cipher key, first subkey in bits 127:112 |
| ct_o | output | 64 | Ciphertext of the latest completed encryption |
| done_o | output | 1 | One-cycle pulse when `ct_o` is updated |

## Verification
Some properties are checked by assertions on every cycle:
- `done_o` never stays high for two cycles in a row.
- The round counter never passes the output step.
- A start that arrives while the core is busy does not restart it.
- `ct_o` changes only together with `done_o`.
- Multiplying by one leaves the other operand unchanged.

Other behaviour can only be shown by the bench's scenarios:
- The ciphertext values themselves.
- The correct subkey order across the rotations.
- The exact nine-clock latency.
- Inputs being ignored after capture.

The bench checks these against a separate model that reduces full products modulo 65537 and builds the subkeys by explicit rotations.

// File: rtl/idea_pkg.sv
package idea_pkg;
    localparam int WW      = 16;
    localparam int NW      = 4;
    localparam int BLK     = WW * NW;
    localparam int KW      = 128;
    localparam int KROT    = 25;
    localparam int ROUNDS  = 8;
    localparam int KPR     = 6;
    localparam int KPERSET = KW / WW;
    localparam int RCW     = $clog2(ROUNDS + 1);

    typedef logic [WW-1:0] word_t;

    typedef struct packed {
        word_t w1;
        word_t w2;
        word_t w3;
        word_t w4;
    } blk_t;

    // element 0 is the first subkey consumed by a round
    typedef word_t [KPR-1:0] rkeys_t;

    // bit offset (from the MSB) of subkey idx within the unrotated key
    function automatic int unsigned sk_offset(input int unsigned idx);
        return (WW * (idx % KPERSET) + KROT * (idx / KPERSET)) % KW;
    endfunction
endpackage

// File: rtl/idea_mulmod.sv
module idea_mulmod #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] p_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [2*W-1:0] prod;
    logic [W-1:0]   lo, hi;

    always_comb begin
        prod = a_i * b_i;
        lo   = prod[W-1:0];
        hi   = prod[2*W-1:W];
        if (a_i == '0)
            p_o = ONE - b_i;
        else if (b_i == '0)
            p_o = ONE - a_i;
        else
            p_o = lo - hi + ((lo < hi) ? ONE : '0);
    end

    // R4: one is the multiplicative identity, zero meaning 2^W included
    always_comb begin
        if (a_i == ONE)
            a_r4_mul_identity: assert (p_o == b_i);
    end
endmodule

// File: rtl/idea_keysched.sv
module idea_keysched
    import idea_pkg::*;
(
    input  logic [KW-1:0]  key_i,
    input  logic [RCW-1:0] rnd_i,
    output rkeys_t         sk_o
);
    for (genvar i = 0; i < KPR; i++) begin : g_sk
        int unsigned    off;
        logic [KW-1:0]  rot;
        always_comb begin
            off = sk_offset(int'(rnd_i) * KPR + i);
            rot = (key_i << off) | (key_i >> (KW - off));
            sk_o[i] = rot[KW-1 -: WW];
        end
    end

    // R5: first subkey of the first round is the top key word
    always_comb begin
        if (rnd_i == '0)
            a_r5_first_subkey: assert (sk_o[0] == key_i[KW-1 -: WW]);
    end
endmodule

// File: rtl/idea_round.sv
module idea_round
    import idea_pkg::*;
(
    input  blk_t   x_i,
    input  rkeys_t k_i,
    input  logic   last_i,
    output blk_t   y_o
);
    word_t y1, y2, y3, y4;
    word_t t0, t1, t2;
    word_t ma_in, ma_mix;

    idea_mulmod #(.W(WW)) u_m1 (.a_i(x_i.w1), .b_i(k_i[0]), .p_o(y1));
    idea_mulmod #(.W(WW)) u_m4 (.a_i(x_i.w4), .b_i(k_i[3]), .p_o(y4));
    idea_mulmod #(.W(WW)) u_m5 (.a_i(ma_in),  .b_i(k_i[4]), .p_o(t0));
    idea_mulmod #(.W(WW)) u_m6 (.a_i(ma_mix), .b_i(k_i[5]), .p_o(t1));

    always_comb begin
        y2     = x_i.w2 + k_i[1];
        y3     = x_i.w3 + k_i[2];
        ma_in  = y1 ^ y3;
        ma_mix = t0 + (y2 ^ y4);
        t2     = t0 + t1;
        if (last_i) begin
            // output step: middle words taken unswapped
            y_o.w1 = y1;
            y_o.w2 = x_i.w3 + k_i[1];
            y_o.w3 = x_i.w2 + k_i[2];
            y_o.w4 = y4;
        end else begin
            y_o.w1 = y1 ^ t1;
            y_o.w2 = y3 ^ t1;
            y_o.w3 = y2 ^ t2;
            y_o.w4 = y4 ^ t2;
        end
    end
endmodule

// File: rtl/idea_enc_core.sv
module idea_enc_core
    import idea_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [BLK-1:0] pt_i,
    input  logic [KW-1:0]  key_i,
    output logic [BLK-1:0] ct_o,
    output logic           done_o
);
    localparam logic [RCW-1:0] LAST = RCW'(ROUNDS);

    logic           busy_q;
    logic [RCW-1:0] rnd_q;
    blk_t           st_q;
    logic [KW-1:0]  key_q;
    rkeys_t         sk;
    blk_t           nxt;
    logic           last;

    assign last = (rnd_q == LAST);

    idea_keysched u_ks (
        .key_i (key_q),
        .rnd_i (rnd_q),
        .sk_o  (sk)
    );

    idea_round u_rnd (
        .x_i    (st_q),
        .k_i    (sk),
        .last_i (last),
        .y_o    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rnd_q  <= '0;
            st_q   <= '0;
            key_q  <= '0;
            ct_o   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    rnd_q  <= '0;
                    st_q   <= pt_i;
                    key_q  <= key_i;
                end
            end else if (last) begin
                ct_o   <= nxt;
                done_o <= 1'b1;
                busy_q <= 1'b0;
            end else begin
                st_q  <= nxt;
                rnd_q <= rnd_q + 1'b1;
            end
        end
    end

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r2_round_bound: assert property (@(posedge clk) disable iff (rst)
        rnd_q <= LAST);

    a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last) |=> (busy_q && rnd_q == $past(rnd_q) + 1'b1));

    a_r7_ct_stable: assert property (@(posedge clk) disable iff (rst)
        !done_o |=> (done_o || $stable(ct_o)));
endmodule

// File: tb/tb_idea_enc_core.sv
module tb_idea_enc_core;
    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic [63:0]  pt_i;
    logic [127:0] key_i;
    logic [63:0]  ct_o;
    logic         done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    idea_enc_core dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .pt_i(pt_i), .key_i(key_i), .ct_o(ct_o), .done_o(done_o)
    );

    function automatic logic [15:0] mm(input logic [15:0] a, input logic [15:0] b);
        longint unsigned aa, bb, r;
        aa = (a == 0) ? 65536 : a;
        bb = (b == 0) ? 65536 : b;
        r  = (aa * bb) % 65537;
        return r[15:0];
    endfunction

    function automatic logic [63:0] ref_enc(input logic [63:0] pt, input logic [127:0] key);
        logic [15:0]  sk [52];
        logic [127:0] k;
        logic [15:0]  x1, x2, x3, x4, a, b, c, d, t0, t1, t2;
        k = key;
        for (int j = 0; j < 52; j++) begin
            if (j > 0 && j % 8 == 0) k = {k[102:0], k[127:103]};
            sk[j] = k[127 - 16*(j%8) -: 16];
        end
        {x1, x2, x3, x4} = pt;
        for (int r = 0; r < 8; r++) begin
            a  = mm(x1, sk[6*r]);
            b  = x2 + sk[6*r+1];
            c  = x3 + sk[6*r+2];
            d  = mm(x4, sk[6*r+3]);
            t0 = mm(a ^ c, sk[6*r+4]);
            t1 = mm(t0 + (b ^ d), sk[6*r+5]);
            t2 = t0 + t1;
            x1 = a ^ t1;
            x2 = c ^ t1;
            x3 = b ^ t2;
            x4 = d ^ t2;
        end
        return {mm(x1, sk[48]), x3 + sk[49], x2 + sk[50], mm(x4, sk[51])};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // start at a negedge; returns at the negedge where done should be high
    task automatic launch(input logic [63:0] pt, input logic [127:0] key);
        @(negedge clk);
        start_i = 1'b1; pt_i = pt; key_i = key;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run(input string req, input logic [63:0] pt, input logic [127:0] key);
        launch(pt, key);
        repeat (9) @(negedge clk);
        chk({req, " done"}, 64'(done_o), 64'd1);
        chk(req, ct_o, ref_enc(pt, key));
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [63:0]  p, p2;
        logic [127:0] k, k2;
        logic [63:0]  held;
        int           pulses;
        void'($urandom(32'd575));
        rst = 1'b1; start_i = 1'b0; pt_i = '0; key_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", 64'(done_o), 64'd0);
        chk("R1 ct", ct_o, 64'd0);

        // R3 published vector, R5 subkey expansion
        run("R3", 64'h0000_0001_0002_0003, 128'h0001_0002_0003_0004_0005_0006_0007_0008);
        chk("R3 known", ct_o, 64'h11FB_ED2B_0198_6DE5);
        chk("R5 model", ref_enc(64'h0000_0001_0002_0003,
            128'h0001_0002_0003_0004_0005_0006_0007_0008), 64'h11FB_ED2B_0198_6DE5);

        // R2 latency: low at cycle 8, high at 9, low at 10
        p = 64'h0123_4567_89AB_CDEF; k = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
        launch(p, k);
        repeat (8) @(negedge clk);
        chk("R2 early", 64'(done_o), 64'd0);
        @(negedge clk);
        chk("R2 on time", 64'(done_o), 64'd1);
        @(negedge clk);
        chk("R2 one cycle", 64'(done_o), 64'd0);

        // R4 zero and all-ones operands
        run("R4 zeros", 64'h0, 128'h0);
        run("R4 ones", 64'hFFFF_FFFF_FFFF_FFFF, {128{1'b1}});
        run("R4 mixed", 64'h0000_FFFF_0000_0001, 128'h0000_0001_FFFF_0000_0000_0000_0001_0000);

        // R6 start while busy is ignored
        p = 64'hDEAD_BEEF_0BAD_F00D; k = 128'h1357_9BDF_0246_8ACE_FEDC_BA98_7654_3210;
        launch(p, k);
        repeat (3) @(negedge clk);
        start_i = 1'b1; pt_i = 64'h1; key_i = 128'h2;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 done", 64'(done_o), 64'd1);
        chk("R6 result", ct_o, ref_enc(p, k));
        pulses = 0;
        repeat (12) begin
            @(negedge clk);
            if (done_o) pulses++;
        end
        chk("R6 no extra done", 64'(pulses), 64'd0);

        // R7 output holds while idle
        held = ct_o;
        repeat (5) @(negedge clk);
        chk("R7 hold", ct_o, held);

        // R8 inputs changed after capture have no effect
        p = 64'hA5A5_5A5A_3C3C_C3C3; k = 128'hFEED_FACE_CAFE_BABE_0BAD_C0DE_1234_5678;
        launch(p, k);
        pt_i = ~p; key_i = ~k;
        repeat (9) @(negedge clk);
        chk("R8 capture", ct_o, ref_enc(p, k));
        // R7 stable during a run until done
        held = ct_o;
        launch(~p, ~k);
        repeat (8) @(negedge clk);
        chk("R7 stable mid-run", ct_o, held);
        @(negedge clk);
        chk("R7 update", ct_o, ref_enc(~p, ~k));

        // R3 random vectors
        for (int i = 0; i < 24; i++) begin
            p2 = {$urandom(), $urandom()};
            k2 = {$urandom(), $urandom(), $urandom(), $urandom()};
            run("R3 random", p2, k2);
        end
        summary();
    end
endmodule